// File: doc/BRIEF.md
# Step Attenuator Control Front End

This block produces the registered 6-bit, active-low control word that drives the switch array of a step attenuator. The step size is 0.5 dB. In the word, a low bit switches its section in and a high bit bypasses it. From bit 0 up to bit 5 the section weights are 0.5, 1, 2, 4, 8 and 16 dB. All ones is the 0 dB reference and all zeros is 31.5 dB.

A mode input chooses between two sources for the word. In serial mode the word comes from a three-wire shift path with data, clock and load strobe. In parallel mode it comes from six parallel inputs. The strobe loads the word in both modes. While the strobe is high the word passes through to the output register, and while it is low the output holds. Holding the strobe high in parallel mode therefore gives direct control.

After reset, a boot timer runs for a parameterised number of system clocks. During that time two strap inputs select one of four preset attenuation levels. If the strobe is high during boot, the parallel inputs are used instead of the straps. A cascade output repeats the serial data six serial clocks later, so that a second device can share the same serial lines.

All control inputs are first brought through a synchroniser into the fast system clock. Serial clock edges are detected inside that clock domain.

The controller is a three-state machine:
- BOOT runs the timer. When the timer expires it goes to LOAD if the strobe is high, otherwise to HOLD.
- HOLD keeps the output word. It goes to LOAD when the strobe rises.
- LOAD copies the selected source into the output register on every cycle. It goes to HOLD when the strobe falls.

Top module: `step_atten_ctrl`

## Requirements
- R1: While reset is asserted, the output word is 6'b000000 (31.5 dB) and the cascade output is 1, because the shift path resets to all ones.
- R2: During the boot time with the strobe low, the output follows the straps as {strap_a,strap_b}: 00 gives 6'h00, 10 gives 6'h0F (24 dB), 01 gives 6'h1F (16 dB), 11 gives 6'h3F (0 dB). If the strobe stays low after boot, that value is kept.
- R3: During the boot time with the strobe high, the output follows the parallel inputs.
- R4: In serial mode (mode_ser=1), six bits are shifted in on rising serial clock edges. The first bit becomes bit 5 and the last becomes bit 0. The shifted word reaches the output while the strobe is high.
- R5: Rising serial clock edges while the strobe is high do not change the shift register.
- R6: The cascade output equals the serial data bit that was captured six rising serial clock edges earlier.
- R7: In parallel mode (mode_ser=0) with the strobe held high, the output follows every change of the parallel inputs.
- R8: In parallel mode with the strobe low, the output holds. A high pulse on the strobe loads the parallel value, and the value is kept after the strobe falls.
- R9: In serial mode with the strobe low, the output does not change while new bits are shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_ser | input | 1 | 1 selects the serial source, 0 selects the parallel source |
| sclk | input | 1 | Serial clock, sampled by the system clock |
| sdata | input | 1 | Serial data |
| latch_en | input | 1 | Load strobe |
| par_bits | input | 6 | Parallel control inputs, active low |
| strap_a | input | 1 | Boot strap, high-order select bit |
| strap_b | input | 1 | Boot strap, low-order select bit |
| casc_out | output | 1 | Serial data delayed by six serial clocks |
| ctrl_word | output | 6 | Registered active-low control word |

## Verification
The assertions check four behaviours on every cycle:
- In HOLD the output register does not change.
- In LOAD the output register takes the shift register value in serial mode and the synchronised parallel value in parallel mode.
- While the synchronised strobe is high, the shift register does not move.
- During boot with the strobe low, the output is always one of the four strap codes.

Some behaviours can only be shown by the bench's scenarios, because they depend on the order of stimulus at the pins:
- which strap pair gives which level;
- the order in which serial bits land in the word;
- the six-clock cascade delay;
- the level kept after boot ends.

// File: rtl/attn_pkg.sv
package attn_pkg;
    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_HOLD = 2'd1,
        ST_LOAD = 2'd2
    } attn_state_t;
endpackage

// File: rtl/attn_sync.sv
module attn_sync #(
    parameter int W      = 10,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[0] <= '0;
                    else        pipe[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[s] <= '0;
                    else        pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/attn_shift.sv
module attn_shift #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word,
    output logic         casc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        word <= '1;
        else if (shift_en) word <= {word[W-2:0], bit_in};
    end

    assign casc = word[W-1];
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl #(
    parameter int WORD_W       = 6,
    parameter int SYNC_STAGES  = 2,
    parameter int PWRUP_CYCLES = 10_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ser,
    input  logic              sclk,
    input  logic              sdata,
    input  logic              latch_en,
    input  logic [WORD_W-1:0] par_bits,
    input  logic              strap_a,
    input  logic              strap_b,
    output logic              casc_out,
    output logic [WORD_W-1:0] ctrl_word
);
    import attn_pkg::*;

    localparam int SYNC_W = WORD_W + 4;
    localparam int CNT_W  = $clog2(PWRUP_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PWRUP_CYCLES - 1);
    localparam logic [WORD_W-1:0] CODE_MAX = '0;
    localparam logic [WORD_W-1:0] CODE_REF = '1;
    localparam logic [WORD_W-1:0] CODE_TOP = ~(WORD_W'(1) << (WORD_W - 1));
    localparam logic [WORD_W-1:0] CODE_TWO = ~(WORD_W'(3) << (WORD_W - 2));

    logic [SYNC_W-1:0] sync_out;
    logic              mode_s, le_s, sclk_s, sdata_s, sclk_d;
    logic [WORD_W-1:0] par_s, shreg;
    logic              shift_en;
    attn_state_t       state_q, state_n;
    logic [CNT_W-1:0]  boot_cnt;
    logic [WORD_W-1:0] strap_code;

    attn_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({mode_ser, latch_en, sclk, sdata, par_bits}),
        .dout (sync_out)
    );

    assign {mode_s, le_s, sclk_s, sdata_s, par_s} = sync_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    // serial clock is masked while the strobe is high
    assign shift_en = sclk_s && !sclk_d && !le_s;

    attn_shift #(.W(WORD_W)) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .bit_in  (sdata_s),
        .word    (shreg),
        .casc    (casc_out)
    );

    always_comb begin
        unique case ({strap_a, strap_b})
            2'b00:   strap_code = CODE_MAX;
            2'b10:   strap_code = CODE_TWO;
            2'b01:   strap_code = CODE_TOP;
            default: strap_code = CODE_REF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  boot_cnt <= '0;
        else if (state_q == ST_BOOT) boot_cnt <= boot_cnt + 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_BOOT: if (boot_cnt == CNT_LAST) state_n = le_s ? ST_LOAD : ST_HOLD;
            ST_HOLD: if (le_s)                 state_n = ST_LOAD;
            ST_LOAD: if (!le_s)                state_n = ST_HOLD;
            default:                           state_n = ST_BOOT;
        endcase
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_word <= CODE_MAX;
        end else begin
            unique case (state_q)
                ST_BOOT: ctrl_word <= le_s ? par_s : strap_code;
                ST_LOAD: ctrl_word <= mode_s ? shreg : par_s;
                default: ctrl_word <= ctrl_word;
            endcase
        end
    end
endmodule

// File: rtl/attn_ctrl_checker.sv
module attn_ctrl_checker #(
    parameter int WORD_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        state,
    input logic              le_s,
    input logic              mode_s,
    input logic [WORD_W-1:0] shreg,
    input logic [WORD_W-1:0] par_s,
    input logic [WORD_W-1:0] ctrl_word
);
    localparam logic [1:0] S_BOOT = 2'd0;
    localparam logic [1:0] S_HOLD = 2'd1;
    localparam logic [1:0] S_LOAD = 2'd2;
    localparam logic [WORD_W-1:0] C_MAX = '0;
    localparam logic [WORD_W-1:0] C_REF = '1;
    localparam logic [WORD_W-1:0] C_TOP = ~(WORD_W'(1) << (WORD_W - 1));
    localparam logic [WORD_W-1:0] C_TWO = ~(WORD_W'(3) << (WORD_W - 2));

    a_r2_boot_strap: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BOOT && !le_s) |=>
            (ctrl_word == C_MAX || ctrl_word == C_REF ||
             ctrl_word == C_TOP || ctrl_word == C_TWO));

    a_r4_serial_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOAD && mode_s) |=> ctrl_word == $past(shreg));

    a_r5_clock_masked: assert property (@(posedge clk) disable iff (!rst_n)
        le_s |=> $stable(shreg));

    a_r7_parallel_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOAD && !mode_s) |=> ctrl_word == $past(par_s));

    a_r8_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD) |=> $stable(ctrl_word));
endmodule

bind step_atten_ctrl attn_ctrl_checker #(.WORD_W(WORD_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state_q),
    .le_s     (le_s),
    .mode_s   (mode_s),
    .shreg    (shreg),
    .par_s    (par_s),
    .ctrl_word(ctrl_word)
);

// File: tb/test_step_atten_ctrl.sv
module test_step_atten_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_ser = 1'b0, sclk = 1'b0, sdata = 1'b0, latch_en = 1'b0;
    logic [5:0] par_bits = 6'h00;
    logic       strap_a = 1'b0, strap_b = 1'b0;
    logic       casc_out;
    logic [5:0] ctrl_word;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    step_atten_ctrl #(.WORD_W(6), .SYNC_STAGES(2), .PWRUP_CYCLES(20)) i_step_atten_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_ser(mode_ser), .sclk(sclk), .sdata(sdata),
        .latch_en(latch_en), .par_bits(par_bits), .strap_a(strap_a), .strap_b(strap_b),
        .casc_out(casc_out), .ctrl_word(ctrl_word)
    );

    localparam logic [5:0] PAR_VEC [8] = '{6'h3F, 6'h3E, 6'h3D, 6'h3B, 6'h37, 6'h2F, 6'h1F, 6'h00};

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic a, input logic b, input logic le, input logic [5:0] p);
        @(negedge clk);
        rst_n = 1'b0; strap_a = a; strap_b = b; latch_en = le; par_bits = p;
        mode_ser = 1'b0; sclk = 1'b0; sdata = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
    endtask

    task automatic send_bit(input logic b);
        sdata = b; wait_clk(4);
        sclk = 1'b1; wait_clk(4);
        sclk = 1'b0; wait_clk(4);
    endtask

    task automatic send_word(input logic [5:0] w);
        for (int i = 5; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic pulse_le();
        latch_en = 1'b1; wait_clk(6);
        latch_en = 1'b0; wait_clk(6);
    endtask

    initial begin
        wait_clk(100000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset(1'b0, 1'b0, 1'b0, 6'h2A);
        rst_n = 1'b0; wait_clk(1);
        check("R1 reset word", ctrl_word, 6'h00);
        check("R1 reset cascade", {5'b0, casc_out}, 6'h01);
        rst_n = 1'b1;
        wait_clk(8);
        check("R2 straps 00", ctrl_word, 6'h00);

        do_reset(1'b1, 1'b0, 1'b0, 6'h2A); wait_clk(8);
        check("R2 straps 10", ctrl_word, 6'h0F);
        do_reset(1'b0, 1'b1, 1'b0, 6'h2A); wait_clk(8);
        check("R2 straps 01", ctrl_word, 6'h1F);
        do_reset(1'b1, 1'b1, 1'b0, 6'h2A); wait_clk(8);
        check("R2 straps 11", ctrl_word, 6'h3F);
        wait_clk(30);
        check("R2 kept after boot", ctrl_word, 6'h3F);

        // R3 strobe high during boot
        do_reset(1'b0, 1'b0, 1'b1, 6'h2A); wait_clk(10);
        check("R3 boot parallel", ctrl_word, 6'h2A);
        wait_clk(30);

        // R7 direct parallel table
        for (int k = 0; k < 8; k++) begin
            par_bits = PAR_VEC[k];
            wait_clk(6);
            check("R7 direct parallel", ctrl_word, PAR_VEC[k]);
        end

        // R8 latched parallel
        latch_en = 1'b0; wait_clk(6);
        par_bits = 6'h15; wait_clk(8);
        check("R8 hold while low", ctrl_word, 6'h00);
        pulse_le();
        check("R8 pulse loads", ctrl_word, 6'h15);
        par_bits = 6'h33; wait_clk(8);
        check("R8 kept after pulse", ctrl_word, 6'h15);

        // R9 / R4 serial
        mode_ser = 1'b1; wait_clk(4);
        send_word(6'h2D);
        check("R9 serial shift holds output", ctrl_word, 6'h15);
        pulse_le();
        check("R4 serial load MSB first", ctrl_word, 6'h2D);

        // R5 clock masked while strobe high
        latch_en = 1'b1; wait_clk(6);
        for (int k = 0; k < 3; k++) send_bit(1'b0);
        check("R5 masked clock", ctrl_word, 6'h2D);
        latch_en = 1'b0; wait_clk(6);
        pulse_le();
        check("R5 register unchanged", ctrl_word, 6'h2D);

        // R6 cascade delay
        send_word(6'b101100);
        for (int k = 0; k < 6; k++) begin
            check("R6 cascade delay", {5'b0, casc_out}, {5'b0, (6'b101100 >> (5 - k)) & 6'h01});
            send_bit(k[0]);
        end
        check("R6 cascade after word", {5'b0, casc_out}, 6'h00);
        pulse_le();
        check("R4 second word", ctrl_word, 6'b010101);
        send_word(6'h00);
        pulse_le();
        check("R4 full attenuation", ctrl_word, 6'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule